// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for each incoming frame, whether the receive path keeps it or drops it, judging only the 48-bit destination address and the frame length. Software programs two station addresses, a 64-bit group hash table, a receive control word and a general control word through a simple word-write port. The receive front end presents the destination address with a one-cycle strobe together with the frame length. Two clock edges later the block answers with a one-cycle verdict: accept or drop, plus a four-bit reason vector showing which enabled conditions matched.

The group filter is a single-hash Bloom-style table. The address is folded down to a 6-bit index by XOR-ing its eight 6-bit slices, and that index picks one table bit. Multicast destinations always go through the table. Individual destinations go through it only when the control word asks for it. All configuration is copied when the strobe is taken, so a write that lands while a verdict is being formed cannot change that verdict. A separate flag reports when the duplex setting in the receive control word disagrees with the duplex reported by the attached PHY. The flag is refreshed only while a general enable bit is set.

Top module: `rxaddr_filter`

## Requirements
- R1: After reset `dec_valid`, `dec_accept`, `dec_reason` and `duplex_mismatch` are all zero.
- R2: A strobe on `da_valid` sampled at clock edge k makes `dec_valid` high for exactly the cycle after edge k+1, and low after edge k and after edge k+2.
- R3: Word index 0 holds station address 0 bytes 0..3, with byte 0 in bits 7:0. Bits 15:0 of index 1 hold bytes 4 and 5. Byte 0 is bits 7:0 of `da`. With control bit 0 set, an exact match sets reason bit 0.
- R4: Station address 1 uses word indices 2 and 3 with the same layout. With control bit 1 set, an exact match sets reason bit 1. With the enable clear, a match has no effect.
- R5: With control bit 3 set, an all-ones destination sets reason bit 2.
- R6: The hash index is the XOR of `da[6i+5:6i]` for i = 0..7. Table word index 4 holds table bits 0..31 and index 5 holds bits 32..63. A set table bit at the index gives a hash hit, shown as reason bit 3.
- R7: A destination with `da[0]` clear is eligible for the hash lookup only when control bit 2 is set. A destination with `da[0]` set is always eligible.
- R8: A `frame_len` below 12 gives a drop with all reason bits zero, whatever else matches.
- R9: `dec_accept` is high exactly when at least one reason bit is set. Several reasons may be reported together. Outside `dec_valid` both are zero.
- R10: The receive control word is at index 6 (bits 3:0 as above). Writes taken on the strobe edge or on the edge after it do not change the verdict of that strobe.
- R11: General control is at index 7, bit 0, and receive control bit 7 gives the MAC duplex. While the enable bit is set, `duplex_mismatch` takes (control bit 7 XOR `phy_full_duplex`) one edge later. While it is clear, the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_idx | input | 3 | Configuration word index |
| cfg_data | input | 32 | Configuration write data |
| phy_full_duplex | input | 1 | Duplex mode reported by the PHY |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Verdict valid pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 4 | Matches: bit0 station 0, bit1 station 1, bit2 broadcast, bit3 hash |
| duplex_mismatch | output | 1 | MAC/PHY duplex disagreement flag |

## Verification
The verdict is due two edges after the strobe edge. The bench raises the strobe on a falling edge and then looks at the outputs on each of the next three falling edges. It expects no pulse after the first rising edge, the verdict after the second and silence after the third, so a shift of the pulse by a cycle is caught. Configuration writes are held over exactly one rising edge and count as in force after it. The duplex flag is read one falling edge after the edge that saw the changed inputs. The snapshot test places its writes on the strobe edge and on the edge after it, and then expects the old verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned MAC_W   = 48;
  localparam int unsigned HASH_W  = 6;
  localparam int unsigned TBL_N   = 1 << HASH_W;
  localparam int unsigned NUM_ST  = 2;
  localparam int unsigned CTL_W   = 4;
  localparam int unsigned RSN_W   = NUM_ST + 2;
  localparam int unsigned SLICES  = MAC_W / HASH_W;

  // receive control bit positions
  localparam int unsigned CTL_HASH_ALL = 2;
  localparam int unsigned CTL_BCAST    = 3;
  localparam int unsigned CTL_FDX      = 7;

  // reason vector positions (stations occupy 0..NUM_ST-1)
  localparam int unsigned RSN_BCAST = NUM_ST;
  localparam int unsigned RSN_HASH  = NUM_ST + 1;

  typedef struct packed {
    logic [NUM_ST-1:0][MAC_W-1:0] st;
    logic [TBL_N-1:0]             tbl;
    logic [CTL_W-1:0]             ctl;
  } filt_cfg_t;

  // XOR of consecutive HASH_W-bit slices of the address
  function automatic logic [HASH_W-1:0] fold_hash(input logic [MAC_W-1:0] a);
    logic [HASH_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SLICES; i++) acc ^= a[i*HASH_W +: HASH_W];
    return acc;
  endfunction

  function automatic logic tbl_lookup(input logic [TBL_N-1:0] tbl,
                                      input logic [HASH_W-1:0] idx);
    return tbl[idx];
  endfunction

endpackage

// File: rtl/rxf_regbank.sv
module rxf_regbank
  import rxf_pkg::*;
#(
  parameter int unsigned REG_AW = 3,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_idx,
  input  logic [DW-1:0]     cfg_data,
  input  logic              phy_full_duplex,
  output filt_cfg_t         cfg,
  output logic              duplex_mismatch
);
  localparam int unsigned HI_W    = MAC_W - DW;
  localparam int unsigned IDX_TLO = 2 * NUM_ST;
  localparam int unsigned IDX_THI = IDX_TLO + 1;
  localparam int unsigned IDX_CTL = IDX_TLO + 2;
  localparam int unsigned IDX_GEN = IDX_TLO + 3;

  filt_cfg_t cfg_q;
  logic      fdx_q;
  logic      gen_en_q;
  logic      dup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      fdx_q    <= 1'b0;
      gen_en_q <= 1'b0;
    end else if (cfg_wr) begin
      for (int i = 0; i < NUM_ST; i++) begin
        if (cfg_idx == REG_AW'(2*i))
          cfg_q.st[i][DW-1:0] <= cfg_data;
        if (cfg_idx == REG_AW'(2*i+1))
          cfg_q.st[i][MAC_W-1:DW] <= cfg_data[HI_W-1:0];
      end
      if (cfg_idx == REG_AW'(IDX_TLO)) cfg_q.tbl[DW-1:0]     <= cfg_data;
      if (cfg_idx == REG_AW'(IDX_THI)) cfg_q.tbl[TBL_N-1:DW] <= cfg_data;
      if (cfg_idx == REG_AW'(IDX_CTL)) begin
        cfg_q.ctl <= cfg_data[CTL_W-1:0];
        fdx_q     <= cfg_data[CTL_FDX];
      end
      if (cfg_idx == REG_AW'(IDX_GEN)) gen_en_q <= cfg_data[0];
    end
  end

  // duplex comparison, refreshed only while enabled
  logic dup_now;
  assign dup_now = fdx_q ^ phy_full_duplex;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dup_q <= 1'b0;
    else if (gen_en_q) dup_q <= dup_now;
  end

  assign cfg             = cfg_q;
  assign duplex_mismatch = dup_q;

  // R11: flag frozen while the enable is clear
  p_dup_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |=> $stable(dup_q));

  // R11: flag follows the comparison while enabled
  p_dup_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en_q |=> (dup_q == $past(dup_now)));

endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid,
  input  logic [MAC_W-1:0] da,
  input  logic [LEN_W-1:0] frame_len,
  input  filt_cfg_t        cfg,
  output logic             s1_valid,
  output logic [MAC_W-1:0] s1_da,
  output logic [LEN_W-1:0] s1_len,
  output filt_cfg_t        s1_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_da    <= '0;
      s1_len   <= '0;
      s1_cfg   <= '0;
    end else begin
      s1_valid <= da_valid;
      if (da_valid) begin
        s1_da  <= da;
        s1_len <= frame_len;
        s1_cfg <= cfg;   // snapshot: later writes cannot reach this verdict
      end
    end
  end

  // R10: the snapshot only moves on a strobe
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> $stable(s1_cfg) && $stable(s1_da));

endmodule

// File: rtl/rxf_judge.sv
module rxf_judge
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [MAC_W-1:0] s1_da,
  input  logic [LEN_W-1:0] s1_len,
  input  filt_cfg_t        s1_cfg,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [RSN_W-1:0] dec_reason
);
  logic [NUM_ST-1:0] st_hit;
  logic              bcast_hit;
  logic [HASH_W-1:0] hash_idx;
  logic              hash_eligible;
  logic              hash_hit;
  logic              len_ok;
  logic [RSN_W-1:0]  reason_d;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_station
    assign st_hit[g] = s1_cfg.ctl[g] && (s1_da == s1_cfg.st[g]);
  end

  assign bcast_hit     = s1_cfg.ctl[CTL_BCAST] && (&s1_da);
  assign hash_idx      = fold_hash(s1_da);
  assign hash_eligible = s1_cfg.ctl[CTL_HASH_ALL] || s1_da[0];
  assign hash_hit      = hash_eligible && tbl_lookup(s1_cfg.tbl, hash_idx);
  assign len_ok        = (s1_len >= LEN_W'(MIN_LEN));

  always_comb begin
    reason_d = '0;
    if (len_ok) begin
      reason_d[NUM_ST-1:0] = st_hit;
      reason_d[RSN_BCAST]  = bcast_hit;
      reason_d[RSN_HASH]   = hash_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= '0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid && (|reason_d);
      dec_reason <= s1_valid ? reason_d : '0;
    end
  end

  // R2: every captured strobe yields a verdict, and only those do
  p_verdict_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> dec_valid);
  p_verdict_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s1_valid));

  // R8: short frames never accepted
  p_short_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_len < LEN_W'(MIN_LEN))) |=> (!dec_accept && dec_reason == '0));

  // R7: unicast without hash-all never reports a hash hit
  p_hash_elig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_cfg.ctl[CTL_HASH_ALL] && !s1_da[0]) |=> !dec_reason[RSN_HASH]);

  // R9: quiet outside the pulse
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_reason == '0));

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned REG_AW  = 3,
  parameter int unsigned DW      = 32,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_idx,
  input  logic [DW-1:0]     cfg_data,
  input  logic              phy_full_duplex,
  input  logic              da_valid,
  input  logic [MAC_W-1:0]  da,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [RSN_W-1:0]  dec_reason,
  output logic              duplex_mismatch
);
  filt_cfg_t        cfg;
  filt_cfg_t        s1_cfg;
  logic             s1_valid;
  logic [MAC_W-1:0] s1_da;
  logic [LEN_W-1:0] s1_len;

  rxf_regbank #(.REG_AW(REG_AW), .DW(DW)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_idx         (cfg_idx),
    .cfg_data        (cfg_data),
    .phy_full_duplex (phy_full_duplex),
    .cfg             (cfg),
    .duplex_mismatch (duplex_mismatch)
  );

  rxf_capture #(.LEN_W(LEN_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .da_valid  (da_valid),
    .da        (da),
    .frame_len (frame_len),
    .cfg       (cfg),
    .s1_valid  (s1_valid),
    .s1_da     (s1_da),
    .s1_len    (s1_len),
    .s1_cfg    (s1_cfg)
  );

  rxf_judge #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid   (s1_valid),
    .s1_da      (s1_da),
    .s1_len     (s1_len),
    .s1_cfg     (s1_cfg),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_reason (dec_reason)
  );

  // R2: the verdict pulse lasts one cycle for an isolated strobe
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !s1_valid) |=> !dec_valid);

endmodule

// File: tb/rxaddr_filter_tb.sv
module rxaddr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        phy_fd = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic [15:0] frame_len = '0;
  logic        dec_valid, dec_accept, duplex_mismatch;
  logic [3:0]  dec_reason;

  int checks = 0;
  int bad = 0;
  logic [31:0] sh [8];

  always #2.5 clk = ~clk;

  rxaddr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .phy_full_duplex(phy_fd), .da_valid(da_valid),
    .da(da), .frame_len(frame_len), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason),
    .duplex_mismatch(duplex_mismatch)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  // bitwise restatement of the slice fold: bit b lands on index bit b mod 6
  function automatic logic [5:0] bhash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int b = 0; b < 48; b++) h[b % 6] ^= a[b];
    return h;
  endfunction

  function automatic logic [3:0] exp_rsn(input logic [47:0] a, input logic [15:0] l);
    logic [3:0]  r = '0;
    logic [63:0] tb = {sh[5], sh[4]};
    if (l < 16'd12) return 4'd0;
    r[0] = sh[6][0] && (a == {sh[1][15:0], sh[0]});
    r[1] = sh[6][1] && (a == {sh[3][15:0], sh[2]});
    r[2] = sh[6][3] && (a == 48'hFFFF_FFFF_FFFF);
    r[3] = (sh[6][2] || a[0]) && tb[bhash(a)];
    return r;
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    sh[idx] = d;
  endtask

  task automatic frame(input logic [47:0] a, input logic [15:0] l, input string tag);
    logic [3:0] e;
    e = exp_rsn(a, l);
    @(negedge clk);
    da_valid = 1'b1; da = a; frame_len = l;
    @(negedge clk);
    da_valid = 1'b0;
    chk("R2 no early pulse", {63'd0, dec_valid}, 64'd0);
    @(negedge clk);
    chk("R2 pulse due", {63'd0, dec_valid}, 64'd1);
    chk({tag, " accept"}, {63'd0, dec_accept}, {63'd0, |e});
    chk({tag, " reason"}, {60'd0, dec_reason}, {60'd0, e});
    @(negedge clk);
    chk("R2 single pulse", {63'd0, dec_valid}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", {63'd0, dec_valid}, 64'd0);
    chk("R1 accept", {63'd0, dec_accept}, 64'd0);
    chk("R1 reason", {60'd0, dec_reason}, 64'd0);
    chk("R1 dup", {63'd0, duplex_mismatch}, 64'd0);
  endtask

  task automatic t_station();
    logic [47:0] a0 = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    logic [47:0] a1 = mk(8'h06, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5);
    wr(0, 32'h3322_1102); wr(1, 32'hFFFF_5544);
    wr(2, 32'hC3B2_A106); wr(3, 32'h0000_E5D4);
    wr(4, 0); wr(5, 0);
    wr(6, 32'h1);
    frame(a0, 16'd64, "R3 st0 hit");
    frame(a1, 16'd64, "R4 st1 disabled");
    frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 16'd64, "R3 byte5 differs");
    wr(6, 32'h2);
    frame(a1, 16'd64, "R4 st1 hit");
    frame(a0, 16'd64, "R3 st0 disabled");
    wr(6, 32'h3);
    frame(a0, 16'd64, "R3 both enabled");
    frame(a1, 16'd64, "R4 both enabled");
  endtask

  task automatic t_bcast();
    wr(4, 0); wr(5, 0);
    wr(6, 32'h8);
    frame(48'hFFFF_FFFF_FFFF, 16'd60, "R5 bcast on");
    wr(6, 32'h0);
    frame(48'hFFFF_FFFF_FFFF, 16'd60, "R5 bcast off");
  endtask

  task automatic t_hash();
    wr(6, 32'h0);
    for (int i = 0; i < 8; i++) begin
      logic [47:0] a;
      logic [63:0] t;
      a = mk(8'h01 | 8'(i * 8'h1C), 8'(i * 8'h35), 8'h5E, 8'(8'h91 ^ i),
             8'(i * 8'h47), 8'h0F);
      t = 64'd1 << bhash(a);
      wr(4, t[31:0]); wr(5, t[63:32]);
      frame(a, 16'd64, "R6 hash hit");
      t = ~t;
      wr(4, t[31:0]); wr(5, t[63:32]);
      frame(a, 16'd64, "R6 hash miss");
    end
  endtask

  task automatic t_indiv();
    logic [47:0] a = mk(8'h40, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    wr(6, 32'h0);
    frame(a, 16'd64, "R7 unicast not eligible");
    wr(6, 32'h4);
    frame(a, 16'd64, "R7 unicast with hash-all");
    wr(6, 32'h0);
    frame(a | 48'h1, 16'd64, "R7 multicast eligible");
  endtask

  task automatic t_short();
    wr(0, 32'h3322_1102); wr(1, 32'h0000_5544);
    wr(4, 0); wr(5, 0);
    wr(6, 32'h1);
    frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 16'd11, "R8 len 11");
    frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 16'd0, "R8 len 0");
    frame(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 16'd12, "R8 len 12");
  endtask

  task automatic t_or();
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h0000_FFFF);
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    wr(6, 32'hF);
    frame(48'hFFFF_FFFF_FFFF, 16'd64, "R9 multiple reasons");
    chk("R9 reason combo", {60'd0, exp_rsn(48'hFFFF_FFFF_FFFF, 16'd64)}, 64'hD);
  endtask

  task automatic t_snapshot();
    logic [47:0] a = mk(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F);
    wr(0, 32'h0D0C_0B0A); wr(1, 32'h0000_0F0E);
    wr(4, 0); wr(5, 0);
    wr(6, 32'h1);
    @(negedge clk);
    da_valid = 1'b1; da = a; frame_len = 16'd64;
    cfg_wr = 1'b1; cfg_idx = 3'd6; cfg_data = 32'h0;
    @(negedge clk);
    da_valid = 1'b0;
    cfg_idx = 3'd0; cfg_data = 32'hDEAD_BEEF;
    @(negedge clk);
    cfg_wr = 1'b0;
    sh[6] = 32'h0; sh[0] = 32'hDEAD_BEEF;
    chk("R10 pulse", {63'd0, dec_valid}, 64'd1);
    chk("R10 old config accept", {63'd0, dec_accept}, 64'd1);
    chk("R10 old config reason", {60'd0, dec_reason}, 64'd1);
    frame(a, 16'd64, "R10 new config applies");
  endtask

  task automatic t_duplex();
    phy_fd = 1'b0;
    wr(6, 32'h80);
    wr(7, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R11 hold while disabled", {63'd0, duplex_mismatch}, 64'd0);
    wr(7, 32'h1);
    @(negedge clk);
    chk("R11 mismatch", {63'd0, duplex_mismatch}, 64'd1);
    phy_fd = 1'b1;
    @(negedge clk);
    chk("R11 agree", {63'd0, duplex_mismatch}, 64'd0);
    wr(7, 32'h0);
    phy_fd = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 frozen", {63'd0, duplex_mismatch}, 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) sh[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_station();
    t_bcast();
    t_hash();
    t_indiv();
    t_short();
    t_or();
    t_snapshot();
    t_duplex();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule